// File: doc/BRIEF.md
# Light-Load Burst Mode Controller

This block is the sequencing logic that moves a fixed-frequency flyback PWM supervisor into and out of a low-power burst mode. Its inputs are four digitized comparator flags on the feedback voltage and a free-running time-base tick. Its outputs tell the rest of the controller three things: whether burst mode is active, whether bias and switching are allowed, and whether the peak current limit is set to the reduced level. The analog comparators, the feedback network and the switching stage sit outside this block.

Entry needs the feedback to stay below the entry level for a blanking window. The window is counted in ticks, so that a sudden load step does not cause a false entry. Inside the mode, switching bursts follow a two-level hysteresis on feedback. A third, higher level ends the mode at once. A synchronous clear, driven while the supply is under its lockout level, returns the block to normal operation. The active-low asynchronous reset does the same.

Top module: `lite_burst_ctrl`

## Requirements
- R1: After reset the outputs are burst_o=0, bias_en_o=1, ilim_low_o=0 and ovp_inhibit_o=0.
- R2: In normal operation the blanking counter advances by one on each clock where tick_i=1 and fb_below_entry_i=1. burst_o rises one clock after the clock that registers the BLANK_TICKS-th counted tick, provided fb_below_entry_i is still 1 at that point.
- R3: Any clock with fb_below_entry_i=0 clears the blanking counter, so the next entry attempt needs a full BLANK_TICKS ticks again.
- R4: On the clock that burst_o rises, bias_en_o falls to 0.
- R5: In burst mode with bias off, fb_above_wake_i=1 (feedback above the wake level) sets bias_en_o=1 on the next clock.
- R6: In burst mode with bias on, fb_above_stop_i=0 (feedback below the stop level) clears bias_en_o on the next clock. While fb_above_stop_i=1 and fb_above_wake_i=0, bias_en_o keeps its previous value.
- R7: ilim_low_o=1 (reduced current-limit level selected) exactly while burst_o=1.
- R8: In burst mode, fb_above_exit_i=1 leaves the mode on the next clock: burst_o=0, bias_en_o=1, ilim_low_o=0. Exit takes priority over the wake and stop flags.
- R9: ovp_inhibit_o=1 (overvoltage check reported as inhibited) exactly while burst_o=1.
- R10: uvlo_i=1 synchronously returns the block to normal operation on the next clock and clears the blanking counter, which does not advance while uvlo_i=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| uvlo_i | input | 1 | Supply under lockout level; synchronous clear |
| tick_i | input | 1 | Time-base tick, one clock wide |
| fb_below_entry_i | input | 1 | Feedback below the entry level |
| fb_above_stop_i | input | 1 | Feedback above the burst stop level |
| fb_above_wake_i | input | 1 | Feedback above the burst wake level |
| fb_above_exit_i | input | 1 | Feedback above the exit level |
| burst_o | output | 1 | Burst mode active |
| bias_en_o | output | 1 | Bias and switching enabled |
| ilim_low_o | output | 1 | Reduced peak current limit selected |
| ovp_inhibit_o | output | 1 | Overvoltage check inhibited |

## Verification
All outputs decode a single state register, so every result appears at the first rising edge after its cause. Hysteresis, exit and the lockout clear are due one clock after the flag change. Entry is due one clock after the edge that registers the last counted tick, because the expiry decode sits between the counter and the state register. The bench drives inputs and samples outputs on falling edges, and checks entry both one clock early (still off) and on time. Counter clearing is shown at the ports by interrupting a count and then showing that BLANK_TICKS-1 further ticks do not enter the mode.

// File: rtl/lite_burst_pkg.sv
package lite_burst_pkg;
  typedef enum logic [1:0] {
    ST_NORMAL     = 2'd0,
    ST_BURST_IDLE = 2'd1,
    ST_BURST_RUN  = 2'd2
  } burst_state_e;
endpackage

// File: rtl/burst_blank_timer.sv
module burst_blank_timer #(
  parameter int unsigned BLANK_TICKS = 2000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_clr_i,
  input  logic tick_i,
  input  logic below_i,
  output logic expire_o
);
  localparam int unsigned CntW = $clog2(BLANK_TICKS + 1);
  localparam logic [CntW-1:0] CntMax = CntW'(BLANK_TICKS);

  logic [CntW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (sync_clr_i || !below_i) begin
      cnt_q <= '0;
    end else if (tick_i && (cnt_q != CntMax)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign expire_o = below_i && (cnt_q == CntMax);

  // R3
  cnt_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !below_i |=> (cnt_q == '0));
  // R2
  cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (below_i && !tick_i && !sync_clr_i) |=> $stable(cnt_q));
  // R10
  cnt_sync_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_clr_i |=> (cnt_q == '0));
endmodule

// File: rtl/burst_mode_fsm.sv
module burst_mode_fsm
  import lite_burst_pkg::*;
(
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         uvlo_i,
  input  logic         expire_i,
  input  logic         wake_i,
  input  logic         stop_hi_i,
  input  logic         exit_i,
  output burst_state_e state_o
);
  burst_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_NORMAL:     if (expire_i) state_d = ST_BURST_IDLE;
      ST_BURST_IDLE: begin
        if (exit_i)      state_d = ST_NORMAL;
        else if (wake_i) state_d = ST_BURST_RUN;
      end
      ST_BURST_RUN: begin
        if (exit_i)          state_d = ST_NORMAL;
        else if (!stop_hi_i) state_d = ST_BURST_IDLE;
      end
      default:       state_d = ST_NORMAL;
    endcase
    if (uvlo_i) state_d = ST_NORMAL;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_NORMAL;
    else         state_q <= state_d;
  end

  assign state_o = state_q;

  // R8
  exit_prio_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_NORMAL && exit_i) |=> (state_q == ST_NORMAL));
  // R5
  wake_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_BURST_IDLE && wake_i && !exit_i && !uvlo_i) |=> (state_q == ST_BURST_RUN));
  // R6
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_BURST_RUN && stop_hi_i && !exit_i && !uvlo_i) |=> (state_q == ST_BURST_RUN));
  // R10
  uvlo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uvlo_i |=> (state_q == ST_NORMAL));
endmodule

// File: rtl/burst_out_decode.sv
module burst_out_decode
  import lite_burst_pkg::*;
(
  input  burst_state_e state_i,
  output logic         burst_o,
  output logic         bias_en_o,
  output logic         ilim_low_o,
  output logic         ovp_inhibit_o
);
  always_comb begin
    burst_o       = (state_i != ST_NORMAL);
    bias_en_o     = (state_i != ST_BURST_IDLE);
    ilim_low_o    = burst_o;
    ovp_inhibit_o = burst_o;
  end
endmodule

// File: rtl/lite_burst_ctrl.sv
module lite_burst_ctrl #(
  parameter int unsigned BLANK_TICKS = 2000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic uvlo_i,
  input  logic tick_i,
  input  logic fb_below_entry_i,
  input  logic fb_above_stop_i,
  input  logic fb_above_wake_i,
  input  logic fb_above_exit_i,
  output logic burst_o,
  output logic bias_en_o,
  output logic ilim_low_o,
  output logic ovp_inhibit_o
);
  import lite_burst_pkg::*;

  burst_state_e state;
  logic         expire;
  logic         timer_clr;

  assign timer_clr = uvlo_i || (state != ST_NORMAL);

  burst_blank_timer #(.BLANK_TICKS(BLANK_TICKS)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sync_clr_i (timer_clr),
    .tick_i     (tick_i),
    .below_i    (fb_below_entry_i),
    .expire_o   (expire)
  );

  burst_mode_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .uvlo_i    (uvlo_i),
    .expire_i  (expire),
    .wake_i    (fb_above_wake_i),
    .stop_hi_i (fb_above_stop_i),
    .exit_i    (fb_above_exit_i),
    .state_o   (state)
  );

  burst_out_decode u_dec (
    .state_i       (state),
    .burst_o       (burst_o),
    .bias_en_o     (bias_en_o),
    .ilim_low_o    (ilim_low_o),
    .ovp_inhibit_o (ovp_inhibit_o)
  );

  // R4
  entry_bias_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(burst_o) |-> !bias_en_o);
  // R8
  exit_restore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(burst_o) |-> (bias_en_o && !ilim_low_o));
endmodule

// File: tb/lite_burst_ctrl_test.sv
`timescale 1ns/1ps
module lite_burst_ctrl_test;
  localparam int unsigned N = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic uvlo = 1'b0, tick = 1'b0, below = 1'b0, stop_hi = 1'b0, wake = 1'b0, ex = 1'b0;
  logic burst, bias_en, ilim_low, ovp_inh;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  lite_burst_ctrl #(.BLANK_TICKS(N)) uut (
    .clk_i(clk), .rst_ni(rst_n), .uvlo_i(uvlo), .tick_i(tick),
    .fb_below_entry_i(below), .fb_above_stop_i(stop_hi),
    .fb_above_wake_i(wake), .fb_above_exit_i(ex),
    .burst_o(burst), .bias_en_o(bias_en), .ilim_low_o(ilim_low), .ovp_inhibit_o(ovp_inh)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1; step(1); tick = 1'b0;
    end
  endtask

  task automatic quiet();
    below = 0; stop_hi = 0; wake = 0; ex = 0; uvlo = 0; tick = 0;
  endtask

  task automatic enter_burst();
    quiet(); below = 1; pulse_ticks(N); step(1); below = 0;
  endtask

  task automatic t_reset();
    chk("R1 burst", burst, 1'b0);
    chk("R1 bias", bias_en, 1'b1);
    chk("R1 ilim", ilim_low, 1'b0);
    chk("R1 ovp", ovp_inh, 1'b0);
  endtask

  task automatic t_entry();
    quiet(); below = 1;
    pulse_ticks(N - 1); step(3);
    chk("R2 no entry before full window", burst, 1'b0);
    pulse_ticks(1);
    chk("R2 not yet on last tick edge", burst, 1'b0);
    step(1);
    chk("R2 entry", burst, 1'b1);
    chk("R4 bias off", bias_en, 1'b0);
    chk("R7 reduced limit", ilim_low, 1'b1);
    chk("R9 ovp inhibited", ovp_inh, 1'b1);
    quiet(); ex = 1; step(1); ex = 0;
    chk("R8 exit", burst, 1'b0);
  endtask

  task automatic t_interrupt();
    quiet(); below = 1; pulse_ticks(N - 3);
    below = 0; step(1); below = 1;
    pulse_ticks(N - 1); step(2);
    chk("R3 counter restarted", burst, 1'b0);
    pulse_ticks(1); step(1);
    chk("R3 full window after restart", burst, 1'b1);
    quiet(); ex = 1; step(1); quiet();
  endtask

  task automatic t_hysteresis();
    enter_burst();
    stop_hi = 1; step(2);
    chk("R6 held off between levels", bias_en, 1'b0);
    wake = 1; step(1);
    chk("R5 wake", bias_en, 1'b1);
    chk("R7 limit stays reduced", ilim_low, 1'b1);
    wake = 0; step(2);
    chk("R6 held on between levels", bias_en, 1'b1);
    stop_hi = 0; step(1);
    chk("R6 stop", bias_en, 1'b0);
    chk("R6 burst kept", burst, 1'b1);
    wake = 1; stop_hi = 1; ex = 1; step(1);
    chk("R8 exit over wake", burst, 1'b0);
    chk("R8 bias restored", bias_en, 1'b1);
    chk("R8 full limit", ilim_low, 1'b0);
    chk("R9 ovp released", ovp_inh, 1'b0);
    quiet();
  endtask

  task automatic t_exit_from_run();
    enter_burst();
    stop_hi = 1; wake = 1; step(1); wake = 0;
    stop_hi = 0; ex = 1; step(1);
    chk("R8 exit over stop", burst, 1'b0);
    chk("R8 bias on after exit", bias_en, 1'b1);
    quiet();
  endtask

  task automatic t_uvlo();
    enter_burst();
    uvlo = 1; step(1); uvlo = 0;
    chk("R10 clears burst", burst, 1'b0);
    chk("R10 bias on", bias_en, 1'b1);
    quiet(); below = 1; pulse_ticks(N - 2);
    uvlo = 1; pulse_ticks(4); uvlo = 0;
    pulse_ticks(N - 1); step(2);
    chk("R10 counter cleared", burst, 1'b0);
    pulse_ticks(1); step(1);
    chk("R10 entry after fresh window", burst, 1'b1);
    quiet(); uvlo = 1; step(1); quiet();
  endtask

  initial begin
    quiet();
    step(3);
    t_reset();
    rst_n = 1'b1;
    step(2);
    t_reset();
    t_entry();
    t_interrupt();
    t_hysteresis();
    t_exit_from_run();
    t_uvlo();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule